// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes the memory from power-up to an idle, ready state. After a synchronous reset it holds the clock enable low and drives only no-operation commands for a power-up wait. It then raises the clock enable and issues a fixed chain of commands, with a minimum gap after each one. The chain is: precharge of all banks, extended mode register load, base mode register load with the DLL-reset bit set, a second precharge of all banks, and two auto refreshes. An optional last base mode register load follows, with the DLL-reset bit cleared.

Every wait is given in nanoseconds as an elaboration parameter. Each one is turned into controller clock cycles by rounding up against the clock period, with a floor of one cycle. Two flags tell the rest of the controller where the memory stands. `init_done` rises once the gap after the last command has run out. `read_ok` rises separately, once the DLL lock count after the DLL-reset load is complete. The opcodes for both mode registers come in on input ports. The base opcode is captured at the DLL-reset load, and the optional final load reuses that captured value.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high, and for PWR = ceil(PWRUP_NS/tCK) cycles after it is released, `cke` is 0 and the command pins {cs_n,ras_n,cas_n,we_n} carry NOP = 4'b0111, with `addr` and `ba` at 0.
- R2: `cke` goes to 1 exactly one cycle before the first precharge and then stays at 1 until the next reset.
- R3: Each precharge-all drives the command 4'b0010 with addr bit 10 set and all other address and bank bits at 0. The next command comes TRP = ceil(TRP_NS/tCK) cycles later.
- R4: The extended mode load drives the command 4'b0000 with ba = 2'b01 (ba[0]=1) and addr equal to `emr_opcode`. The next command comes TMRD cycles later.
- R5: The base mode load with DLL reset drives 4'b0000 with ba = 2'b00 and addr equal to `mr_opcode` with bit 8 forced to 1. The next command comes TMRD cycles later.
- R6: A second precharge-all follows the base load. It is followed by two auto refreshes (4'b0001, addr and ba at 0), and each refresh is followed by TRFC cycles before the next command.
- R7: With FINAL_MR=1, a last mode load (4'b0000, ba = 2'b00) follows the second refresh gap. Its addr is the `mr_opcode` value captured at the R5 load with bit 8 forced to 0, even if the input has changed since then.
- R8: Every cycle that carries none of the commands above drives NOP, with addr and ba at 0.
- R9: `init_done` rises when the gap after the last command has run out. It then stays at 1 with NOP on the command pins until reset.
- R10: `read_ok` rises exactly DLL_CYC cycles after the cycle that carries the DLL-reset load, and then stays at 1 until reset.
- R11: A reset taken at any point, including in the middle of the sequence or after it has finished, clears both flags and restarts the whole sequence from the power-up wait.
- R12: Each gap in cycles is the wait time divided by the clock period, rounded up, and never less than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| emr_opcode | input | ADDR_W | Operating code for the extended mode register load |
| mr_opcode | input | ADDR_W | Operating code for the base mode register load (bit 8 overridden) |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (opcode during mode loads, bit 10 for precharge-all) |
| ba | output | 2 | Bank address (selects the mode register during loads) |
| init_done | output | 1 | High once the whole command chain and its last gap are complete |
| read_ok | output | 1 | High once the DLL lock count has elapsed |

## Verification
The bench builds the full cycle-by-cycle picture of the pins from the rounded-up gaps and compares every cycle. An off-by-one timer would therefore show up as a command one cycle early or late. A design that raised the clock enable together with the first precharge, or skipped the extra cycle after it, would also fail. The bench changes `mr_opcode` after the DLL-reset load. A design that reads the live input for the final load instead of the captured value sends the wrong opcode, and one that never clears bit 8 leaves the DLL-reset request set. Resets arrive in the middle of the power-up wait, in the middle of the refresh gaps and after completion. A design that keeps stale flags, a stale DLL count or a half-run timer would show it on the restarted run.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [3:0] {
    ST_PWR  = 4'd0,
    ST_CKE  = 4'd1,
    ST_PRE1 = 4'd2,
    ST_EMR  = 4'd3,
    ST_MR   = 4'd4,
    ST_PRE2 = 4'd5,
    ST_REF1 = 4'd6,
    ST_REF2 = 4'd7,
    ST_MR2  = 4'd8,
    ST_DONE = 4'd9
  } step_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_t;

  localparam int unsigned ALLBANK_BIT = 10;
  localparam int unsigned DLLRST_BIT  = 8;

  // Wait time in ns to whole cycles of a clock given in ps, rounded up, floor 1.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_of2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Fixed command order; the final mode load is skipped when not enabled.
  function automatic step_t next_step(input step_t s, input bit final_en);
    step_t n;
    case (s)
      ST_PWR:  n = ST_CKE;
      ST_CKE:  n = ST_PRE1;
      ST_PRE1: n = ST_EMR;
      ST_EMR:  n = ST_MR;
      ST_MR:   n = ST_PRE2;
      ST_PRE2: n = ST_REF1;
      ST_REF1: n = ST_REF2;
      ST_REF2: n = final_en ? ST_MR2 : ST_DONE;
      default: n = ST_DONE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pwrup_step_timer.sv
module pwrup_step_timer #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= RST_VAL;
    end else if (load) begin
      left_q <= load_val;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign expired = (left_q == '0);
endmodule

// File: rtl/pwrup_dll_gate.sv
module pwrup_dll_gate #(
  parameter int unsigned LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready
);
  localparam int unsigned CW = $clog2(LOCK_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= CW'(1);
      run_q <= 1'b1;
    end else if (run_q && (cnt_q != CW'(LOCK_CYC))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready = run_q && (cnt_q == CW'(LOCK_CYC));
endmodule

// File: rtl/pwrup_cmd_drive.sv
module pwrup_cmd_drive
  import pwrup_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  step_t         step,
  input  logic          fresh,
  input  logic [AW-1:0] emr_op,
  input  logic [AW-1:0] mr_live,
  input  logic [AW-1:0] mr_held,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    ba_o
);
  cmd_t cmd;

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    ba_o   = 2'b00;
    if (fresh) begin
      case (step)
        ST_PRE1, ST_PRE2: begin
          cmd = CMD_PRE;
          addr_o[ALLBANK_BIT] = 1'b1;
        end
        ST_EMR: begin
          cmd    = CMD_MRS;
          addr_o = emr_op;
          ba_o   = 2'b01;
        end
        ST_MR: begin
          cmd    = CMD_MRS;
          addr_o = mr_live;
          addr_o[DLLRST_BIT] = 1'b1;
        end
        ST_MR2: begin
          cmd    = CMD_MRS;
          addr_o = mr_held;
          addr_o[DLLRST_BIT] = 1'b0;
        end
        ST_REF1, ST_REF2: cmd = CMD_REF;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned PWRUP_NS = 200000,
  parameter int unsigned TRP_NS   = 20,
  parameter int unsigned TMRD_NS  = 15,
  parameter int unsigned TRFC_NS  = 120,
  parameter int unsigned DLL_CYC  = 200,
  parameter int unsigned ADDR_W   = 14,
  parameter bit          FINAL_MR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] emr_opcode,
  input  logic [ADDR_W-1:0] mr_opcode,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              init_done,
  output logic              read_ok
);
  localparam int unsigned PWR_C  = ns_to_cyc(PWRUP_NS, CLK_PS);
  localparam int unsigned TRP_C  = ns_to_cyc(TRP_NS, CLK_PS);
  localparam int unsigned TMRD_C = ns_to_cyc(TMRD_NS, CLK_PS);
  localparam int unsigned TRFC_C = ns_to_cyc(TRFC_NS, CLK_PS);
  localparam int unsigned MAX_C  = max_of2(max_of2(PWR_C, TRP_C), max_of2(TMRD_C, TRFC_C));
  localparam int unsigned TW     = $clog2(MAX_C + 1);

  step_t             step_q;
  step_t             step_nx;
  logic              fresh_q;
  logic              gap_over;
  logic              ev_step_adv;
  logic              ev_dll_rst;
  logic [ADDR_W-1:0] mr_held_q;
  logic [TW-1:0]     reload_val;

  // Cycles a step occupies (its command cycle plus the gap), minus one.
  function automatic logic [TW-1:0] span_of(input step_t s);
    int unsigned c;
    case (s)
      ST_PRE1, ST_PRE2:      c = TRP_C;
      ST_EMR, ST_MR, ST_MR2: c = TMRD_C;
      ST_REF1, ST_REF2:      c = TRFC_C;
      default:               c = 1;
    endcase
    return TW'(c - 1);
  endfunction

  assign ev_step_adv = gap_over && (step_q != ST_DONE);
  assign step_nx     = next_step(step_q, FINAL_MR);
  assign reload_val  = span_of(step_nx);
  assign ev_dll_rst  = fresh_q && (step_q == ST_MR);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= ST_PWR;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= ev_step_adv;
      if (ev_step_adv) step_q <= step_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mr_held_q <= '0;
    end else if (ev_dll_rst) begin
      mr_held_q <= mr_opcode;
    end
  end

  pwrup_step_timer #(
    .W       (TW),
    .RST_VAL (TW'(PWR_C))
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ev_step_adv),
    .load_val (reload_val),
    .expired  (gap_over)
  );

  pwrup_dll_gate #(
    .LOCK_CYC (DLL_CYC)
  ) u_dll (
    .clk   (clk),
    .rst   (rst),
    .start (ev_dll_rst),
    .ready (read_ok)
  );

  pwrup_cmd_drive #(
    .AW (ADDR_W)
  ) u_drive (
    .step    (step_q),
    .fresh   (fresh_q),
    .emr_op  (emr_opcode),
    .mr_live (mr_opcode),
    .mr_held (mr_held_q),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .addr_o  (addr),
    .ba_o    (ba)
  );

  assign cke       = (step_q != ST_PWR);
  assign init_done = (step_q == ST_DONE);
endmodule

// File: rtl/pwrup_chk.sv
module pwrup_chk #(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned DLL_CYC = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        ba,
  input logic              init_done,
  input logic              read_ok,
  input logic              ev_dll_rst
);
  localparam int unsigned SW = $clog2(DLL_CYC + 2);

  logic [3:0]    cmd_w;
  logic [SW-1:0] since_q;
  logic          armed_q;

  assign cmd_w = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      armed_q <= 1'b0;
    end else if (ev_dll_rst) begin
      since_q <= SW'(1);
      armed_q <= 1'b1;
    end else if (armed_q && (since_q != SW'(DLL_CYC + 1))) begin
      since_q <= since_q + 1'b1;
    end
  end

  p_nop_cke_low_r1: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cmd_w == 4'b0111));

  p_cke_hold_r2: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  p_pre_follows_cke_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |=> (cmd_w == 4'b0010));

  p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_w == 4'b0010) |-> addr[10]);

  p_mode_sel_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_w == 4'b0000) |-> (ba[1] == 1'b0));

  p_dll_bit_r5: assert property (@(posedge clk) disable iff (rst)
    ev_dll_rst |-> ((cmd_w == 4'b0000) && addr[8] && (ba == 2'b00)));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd_w == 4'b0111));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  p_rok_hold_r10: assert property (@(posedge clk) disable iff (rst)
    read_ok |=> read_ok);

  p_rok_window_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(read_ok) |-> (armed_q && (since_q == SW'(DLL_CYC))));
endmodule

bind sdram_pwrup_seq pwrup_chk #(
  .ADDR_W  (ADDR_W),
  .DLL_CYC (DLL_CYC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .addr       (addr),
  .ba         (ba),
  .init_done  (init_done),
  .read_ok    (read_ok),
  .ev_dll_rst (ev_dll_rst)
);

// File: tb/tb_sdram_pwrup_seq.sv
module tb_sdram_pwrup_seq;
  localparam int unsigned CLK_PS   = 10000;
  localparam int unsigned PWRUP_NS = 3000;
  localparam int unsigned TRP_NS   = 20;
  localparam int unsigned TMRD_NS  = 15;
  localparam int unsigned TRFC_NS  = 120;
  localparam int unsigned DLL_CYC  = 200;
  localparam int unsigned AW       = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] emr_opcode = '0;
  logic [AW-1:0] mr_opcode  = '0;
  logic          cke, cs_n, ras_n, cas_n, we_n, init_done, read_ok;
  logic [AW-1:0] addr;
  logic [1:0]    ba;

  always #5 clk = ~clk;

  sdram_pwrup_seq #(
    .CLK_PS(CLK_PS), .PWRUP_NS(PWRUP_NS), .TRP_NS(TRP_NS), .TMRD_NS(TMRD_NS),
    .TRFC_NS(TRFC_NS), .DLL_CYC(DLL_CYC), .ADDR_W(AW), .FINAL_MR(1'b1)
  ) dut (
    .clk(clk), .rst(rst), .emr_opcode(emr_opcode), .mr_opcode(mr_opcode),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done), .read_ok(read_ok)
  );

  typedef struct packed {
    logic          cke;
    logic [3:0]    cmd;
    logic [1:0]    ba;
    logic [AW-1:0] addr;
    logic          done;
    logic          rok;
  } obs_t;

  obs_t        exp_q[$];
  int unsigned idx_q[$];
  int          checks = 0;
  int          fails  = 0;
  bit          mon_on = 1'b0;
  bit          finished = 1'b0;

  int unsigned P, TRPc, TMRDc, TRFCc;
  int unsigned b_pre1, b_emr, b_mr, b_pre2, b_ref1, b_ref2, b_mr2, done_at, rok_at, full_len;

  // R12: count cycles until they cover the wait, at least one.
  function automatic int unsigned cover_cyc(input int unsigned ns);
    int unsigned c = 0;
    while (c * CLK_PS < ns * 1000) c++;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic string tag_of(input int unsigned n);
    if (n < P) return "R1";
    if (n == P) return "R2";
    if (n == b_pre1) return "R3";
    if (n == b_emr) return "R4";
    if (n == b_mr) return "R5";
    if (n == b_pre2 || n == b_ref1 || n == b_ref2) return "R6";
    if (n == b_mr2) return "R7";
    if (n >= done_at) return "R9";
    return "R8 R12";
  endfunction

  function automatic obs_t exp_at(input int unsigned n, input logic [AW-1:0] emr,
                                  input logic [AW-1:0] mr);
    obs_t e;
    e.cke  = (n >= P);
    e.cmd  = 4'b0111;
    e.ba   = 2'b00;
    e.addr = '0;
    e.done = (n >= done_at);
    e.rok  = (n >= rok_at);
    if (n == b_pre1 || n == b_pre2) begin
      e.cmd = 4'b0010; e.addr[10] = 1'b1;
    end else if (n == b_emr) begin
      e.cmd = 4'b0000; e.ba = 2'b01; e.addr = emr;
    end else if (n == b_mr) begin
      e.cmd = 4'b0000; e.addr = mr; e.addr[8] = 1'b1;
    end else if (n == b_ref1 || n == b_ref2) begin
      e.cmd = 4'b0001;
    end else if (n == b_mr2) begin
      e.cmd = 4'b0000; e.addr = mr; e.addr[8] = 1'b0;
    end
    return e;
  endfunction

  // Monitor: pop one expected item per cycle and compare.
  always @(negedge clk) begin
    obs_t        e;
    obs_t        a;
    int unsigned n;
    if (mon_on && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n = idx_q.pop_front();
      a = {cke, cs_n, ras_n, cas_n, we_n, ba, addr, init_done, read_ok};
      checks++;
      if ({a.cke, a.cmd, a.ba, a.addr, a.done} !== {e.cke, e.cmd, e.ba, e.addr, e.done}) begin
        fails++;
        $display("FAIL %s cycle %0d: cke/cmd/ba/addr/done actual %b/%b/%b/%h/%b expected %b/%b/%b/%h/%b",
                 tag_of(n), n, a.cke, a.cmd, a.ba, a.addr, a.done,
                 e.cke, e.cmd, e.ba, e.addr, e.done);
      end
      checks++;
      if (a.rok !== e.rok) begin
        fails++;
        $display("FAIL R10 cycle %0d: read_ok actual %b expected %b", n, a.rok, e.rok);
      end
    end
  end

  task automatic check_reset(input string tag);
    checks++;
    if ({cke, cs_n, ras_n, cas_n, we_n, ba, addr} !== {1'b0, 4'b0111, 2'b00, {AW{1'b0}}}) begin
      fails++;
      $display("FAIL %s reset pins: actual cke=%b cmd=%b ba=%b addr=%h expected cke=0 cmd=0111 ba=00 addr=0",
               tag, cke, {cs_n, ras_n, cas_n, we_n}, ba, addr);
    end
    checks++;
    if ({init_done, read_ok} !== 2'b00) begin
      fails++;
      $display("FAIL %s reset flags: actual done=%b rok=%b expected 0 0", tag, init_done, read_ok);
    end
  endtask

  // Driver: queue the expected cycles, then release reset.
  task automatic launch(input int unsigned ncyc, input logic [AW-1:0] emr,
                        input logic [AW-1:0] mr);
    @(negedge clk);
    emr_opcode = emr;
    mr_opcode  = mr;
    for (int unsigned n = 0; n < ncyc; n++) begin
      exp_q.push_back(exp_at(n, emr, mr));
      idx_q.push_back(n);
    end
    rst = 1'b0;
    @(posedge clk);
    mon_on = 1'b1;
  endtask

  task automatic hit_reset(input string tag);
    rst = 1'b1;
    @(negedge clk);
    mon_on = 1'b0;
    check_reset(tag);
    @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    P      = cover_cyc(PWRUP_NS);
    TRPc   = cover_cyc(TRP_NS);
    TMRDc  = cover_cyc(TMRD_NS);
    TRFCc  = cover_cyc(TRFC_NS);
    b_pre1 = P + 1;
    b_emr  = b_pre1 + TRPc;
    b_mr   = b_emr + TMRDc;
    b_pre2 = b_mr + TMRDc;
    b_ref1 = b_pre2 + TRPc;
    b_ref2 = b_ref1 + TRFCc;
    b_mr2  = b_ref2 + TRFCc;
    done_at = b_mr2 + TMRDc;
    rok_at  = b_mr + DLL_CYC;
    full_len = ((done_at > rok_at) ? done_at : rok_at) + 6;

    repeat (3) @(negedge clk);
    check_reset("R1");

    // Full run; mr_opcode changes after the DLL-reset load (R7 captured value).
    launch(full_len, 14'h0062, 14'h0062);
    repeat (b_mr + 3) @(negedge clk);
    mr_opcode = 14'h3A5C;
    drain();

    // R11: reset after completion clears both flags.
    hit_reset("R11");

    // R11: abort inside the power-up wait.
    launch(P / 2, 14'h0001, 14'h1163);
    repeat (P / 2) @(negedge clk);
    hit_reset("R11");

    // R11: abort inside the first refresh gap (after the DLL count started).
    launch(b_ref1 + 3, 14'h0002, 14'h0021);
    repeat (b_ref1 + 3) @(negedge clk);
    hit_reset("R11");

    // Full run after aborts; opcode has bit 8 set (R5 keeps it, R7 clears it).
    launch(full_len, 14'h0001, 14'h1163);
    drain();

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      summary();
      $finish;
    end
  end
endmodule